// File: doc/BRIEF.md
# Dual-Role Instruction Conflict Cache

This block is a small two-way set-associative store of 48-bit instruction words that sits beside a program sequencer. Its behaviour is chosen per fetch by the address region. A fetch at or above `EXT_BASE` targets slow external memory. For those fetches the block acts as an ordinary instruction cache: a hit returns the stored word, and a miss fetches the word over an external request port of variable latency and then allocates it. A fetch below `EXT_BASE` targets internal memory. For those fetches the block only remembers words whose fetch collided with a data access on the shared program-memory bus. A later hit supplies the word, so the sequencer can skip the contended bus access. No software control selects the role.

The fetch port uses valid/ready. `fetch_ready` is high whenever no external miss is outstanding, and a fetch is taken on a cycle where `fetch_valid` and `fetch_ready` are both high. The sequencer must hold its request while ready is low. Responses carry no back-pressure: `rsp_valid` pulses for one cycle and the sequencer must take it. The external request uses valid/ready: the address is held until `ext_req_ready`, and the word returns later as a one-cycle `ext_rsp_valid`, at least one cycle after the request handshake. For a conflicted internal miss, the sequencer drives the word it finally read from internal memory on `iword`/`iword_valid` before its next fetch. `cache_en` and `flush` are plain level controls.

Top module: `dual_role_icache`

## Requirements
- R1: After reset or a one-cycle `flush`, every line is invalid, so any fetch misses. A fetch taken in the flush cycle never hits, and a pending internal capture is dropped by the flush.
- R2: An accepted fetch with address at or above `EXT_BASE` that misses raises `ext_req_valid` with `ext_req_addr` equal to the fetch address in the next cycle. `fetch_ready` stays low until the word returns. One cycle after `ext_rsp_valid`, `rsp_valid` is high with `rsp_word` equal to `ext_rsp_word` and `rsp_hit` low.
- R3: An accepted fetch that hits gives `rsp_valid` and `rsp_hit` high in the next cycle, with the stored word, and makes no external request.
- R4: A fetch below `EXT_BASE` never makes an external request. On a miss, `rsp_valid` rises in the next cycle with `rsp_hit` low and `rsp_word` zero.
- R5: An internal miss is allocated only if `fetch_conflict` was high when the fetch was taken. Its word is the next `iword` delivered before another fetch. An `iword` after an unconflicted miss, or with nothing pending, is not stored.
- R6: The set index is address bits [4:1]. The whole 32-bit address is compared, so addresses that differ only in bit 0 or bits [31:5] are distinct lines. Each set holds two such lines at once.
- R7: Each set keeps a least-recently-used order that is updated by every hit and every fill. A fill replaces the least-recently-used way.
- R8: While `cache_en` is low, no fetch hits and nothing is allocated. External fetches still go to the external port. Lines already resident are kept and hit again once `cache_en` returns high.
- R9: `ext_req_valid` and `ext_req_addr` stay stable until `ext_req_ready`. At most one external request is outstanding, and `fetch_ready` is high whenever none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Global enable; low bypasses the store |
| flush | input | 1 | Invalidate all lines this cycle |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Fetch request accepted when high with valid |
| fetch_addr | input | 32 | Fetch address |
| fetch_conflict | input | 1 | Fetch collided with a data access on the shared bus |
| iword_valid | input | 1 | Internal word for the last internal fetch is present |
| iword | input | 48 | Internal word |
| ext_req_valid | output | 1 | External read request valid |
| ext_req_ready | input | 1 | External port accepts the request |
| ext_req_addr | output | 32 | External read address |
| ext_rsp_valid | input | 1 | External word returned (one cycle) |
| ext_rsp_word | input | 48 | External word |
| rsp_valid | output | 1 | Fetch response valid (one cycle) |
| rsp_hit | output | 1 | Response word came from the store |
| rsp_word | output | 48 | Response word (zero on internal miss) |

## Verification
A valid bit that survives a flush shows up as `rsp_hit` high with a stale word on the next fetch to that set, one cycle after acceptance. A wrong LRU bit stays hidden until a third distinct address lands in the same set. After that, the line that should still be resident misses and shows an unexpected external request. A lost or spurious internal capture shows only when the same internal address is fetched again, as the wrong `rsp_hit` value. The bench therefore re-fetches addresses soon after each fill, flush and enable change.

// File: rtl/ccache_pkg.sv
package ccache_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } ctl_state_e;
endpackage

// File: rtl/ccache_tags.sv
module ccache_tags #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_way,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_idx,
  input  logic              touch_way,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_way
);
  import ccache_pkg::*;

  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [ADDR_W-1:0]   tag_q   [SETS][NUM_WAYS];
  logic [SETS-1:0]     lru_q;
  logic [NUM_WAYS-1:0] way_match;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_addr);
  end

  assign lk_hit   = |way_match;
  assign lk_way   = way_match[1];
  assign fill_way = lru_q[fill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      lru_q <= '0;
    end else begin
      if (touch_en) lru_q[touch_idx] <= ~touch_way;
      if (fill_en) begin
        valid_q[fill_idx][fill_way] <= 1'b1;
        lru_q[fill_idx]             <= ~fill_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) tag_q[fill_idx][fill_way] <= fill_addr;
  end
endmodule

// File: rtl/ccache_data.sv
module ccache_data #(
  parameter int DATA_W = 48,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_way,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_way,
  output logic [DATA_W-1:0] rd_word
);
  import ccache_pkg::*;

  logic [DATA_W-1:0] mem_q [SETS][NUM_WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx][wr_way] <= wr_word;
  end

  assign rd_word = mem_q[rd_idx][rd_way];
endmodule

// File: rtl/ccache_ctrl.sv
module ccache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 48,
  parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0040_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_conflict,
  input  logic              iword_valid,
  input  logic [DATA_W-1:0] iword,
  output logic              ext_req_valid,
  input  logic              ext_req_ready,
  output logic [ADDR_W-1:0] ext_req_addr,
  input  logic              ext_rsp_valid,
  input  logic [DATA_W-1:0] ext_rsp_word,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_word,
  input  logic              lk_hit,
  input  logic              lk_way,
  input  logic [DATA_W-1:0] rd_word,
  output logic              touch_en,
  output logic              touch_way,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_word
);
  import ccache_pkg::*;

  ctl_state_e        st_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic              miss_alloc_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              rsp_valid_q;
  logic              rsp_hit_q;
  logic [DATA_W-1:0] rsp_word_q;

  logic accept, is_ext, use_hit, ext_fill, int_fill, in_wait;

  assign in_wait     = (st_q == ST_WAIT);
  assign fetch_ready = (st_q == ST_IDLE);
  assign accept      = fetch_valid && fetch_ready;
  assign is_ext      = (fetch_addr >= EXT_BASE);
  assign use_hit     = accept && cache_en && !flush && lk_hit;

  assign touch_en  = use_hit;
  assign touch_way = lk_way;

  assign ext_fill  = in_wait && ext_rsp_valid && miss_alloc_q && cache_en && !flush;
  assign int_fill  = (st_q == ST_IDLE) && pend_q && iword_valid && cache_en && !flush;
  assign fill_en   = ext_fill || int_fill;
  assign fill_addr = in_wait ? miss_addr_q : pend_addr_q;
  assign fill_word = in_wait ? ext_rsp_word : iword;

  assign ext_req_valid = (st_q == ST_REQ);
  assign ext_req_addr  = miss_addr_q;

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_word  = rsp_word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      miss_addr_q  <= '0;
      miss_alloc_q <= 1'b0;
      pend_q       <= 1'b0;
      pend_addr_q  <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_word_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      if (int_fill || flush) pend_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (use_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              rsp_word_q  <= rd_word;
              pend_q      <= 1'b0;
            end else if (is_ext) begin
              st_q         <= ST_REQ;
              miss_addr_q  <= fetch_addr;
              miss_alloc_q <= cache_en;
              pend_q       <= 1'b0;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_word_q  <= '0;
              pend_q      <= cache_en && fetch_conflict && !flush;
              pend_addr_q <= fetch_addr;
            end
          end
        end
        ST_REQ: begin
          if (ext_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ext_rsp_valid) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_word_q  <= ext_rsp_word;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_role_icache.sv
module dual_role_icache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 48,
  parameter int SETS    = 16,
  parameter int IDX_LSB = 1,
  parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0040_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_conflict,
  input  logic              iword_valid,
  input  logic [DATA_W-1:0] iword,
  output logic              ext_req_valid,
  input  logic              ext_req_ready,
  output logic [ADDR_W-1:0] ext_req_addr,
  input  logic              ext_rsp_valid,
  input  logic [DATA_W-1:0] ext_rsp_word,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_word
);
  localparam int IDX_W = $clog2(SETS);

  logic [IDX_W-1:0]  lk_idx, fill_idx;
  logic              lk_hit, lk_way, touch_en, touch_way, fill_en, fill_way;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_word, rd_word;

  assign lk_idx   = fetch_addr[IDX_LSB +: IDX_W];
  assign fill_idx = fill_addr[IDX_LSB +: IDX_W];

  ccache_tags #(.ADDR_W(ADDR_W), .SETS(SETS)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_idx(lk_idx), .lk_addr(fetch_addr), .lk_hit(lk_hit), .lk_way(lk_way),
    .touch_en(touch_en), .touch_idx(lk_idx), .touch_way(touch_way),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_addr(fill_addr), .fill_way(fill_way)
  );

  ccache_data #(.DATA_W(DATA_W), .SETS(SETS)) u_data (
    .clk(clk), .wr_en(fill_en), .wr_idx(fill_idx), .wr_way(fill_way), .wr_word(fill_word),
    .rd_idx(lk_idx), .rd_way(lk_way), .rd_word(rd_word)
  );

  ccache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_BASE(EXT_BASE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_conflict(fetch_conflict), .iword_valid(iword_valid), .iword(iword),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready), .ext_req_addr(ext_req_addr),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_word(ext_rsp_word),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word(rsp_word),
    .lk_hit(lk_hit), .lk_way(lk_way), .rd_word(rd_word),
    .touch_en(touch_en), .touch_way(touch_way),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_word(fill_word)
  );
endmodule

// File: rtl/dual_role_icache_chk.sv
module dual_role_icache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 48,
  parameter logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0040_0000)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_en,
  input logic              flush,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              ext_req_valid,
  input logic              ext_req_ready,
  input logic [ADDR_W-1:0] ext_req_addr,
  input logic              ext_rsp_valid,
  input logic [DATA_W-1:0] ext_rsp_word,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_word
);
  assert_flush_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> !$past(flush));

  assert_ext_word_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit && $past(ext_rsp_valid && !fetch_ready) |-> rsp_word == $past(ext_rsp_word));

  assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(fetch_valid && fetch_ready));

  assert_int_no_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && (fetch_addr < EXT_BASE) |=> !ext_req_valid);

  assert_disabled_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> $past(cache_en));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid && !ext_req_ready |=> ext_req_valid && $stable(ext_req_addr));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req_valid |-> !fetch_ready);

  assert_req_from_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_req_valid) |-> $past(fetch_valid && fetch_ready) && ext_req_addr == $past(fetch_addr));
endmodule

bind dual_role_icache dual_role_icache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_BASE(EXT_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
  .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
  .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready), .ext_req_addr(ext_req_addr),
  .ext_rsp_valid(ext_rsp_valid), .ext_rsp_word(ext_rsp_word),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word(rsp_word)
);

// File: tb/dual_role_icache_bench.sv
module dual_role_icache_bench;
  localparam logic [31:0] EXT_BASE = 32'h0040_0000;
  localparam logic [31:0] INT_BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_addr = '0;
  logic        fetch_conflict = 1'b0;
  logic        iword_valid = 1'b0;
  logic [47:0] iword = '0;
  logic        ext_req_valid;
  logic        ext_req_ready = 1'b0;
  logic [31:0] ext_req_addr;
  logic        ext_rsp_valid = 1'b0;
  logic [47:0] ext_rsp_word = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [47:0] rsp_word;

  int checks = 0;
  int fails = 0;
  int ext_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_role_icache u_dual_role_icache (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .fetch_conflict(fetch_conflict), .iword_valid(iword_valid), .iword(iword),
    .ext_req_valid(ext_req_valid), .ext_req_ready(ext_req_ready), .ext_req_addr(ext_req_addr),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_word(ext_rsp_word),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_word(rsp_word)
  );

  always @(posedge clk) if (ext_req_valid && ext_req_ready) ext_cnt++;

  // reference state
  bit          m_valid [16][2];
  logic [31:0] m_tag   [16][2];
  logic [47:0] m_data  [16][2];
  bit          m_lru   [16];
  bit          m_pend;
  logic [31:0] m_pend_addr;

  function automatic logic [47:0] ext_word(input logic [31:0] a);
    return {a[15:0], a ^ 32'hA5A5_0F0F};
  endfunction

  function automatic logic [47:0] int_word(input logic [31:0] a);
    return {~a[15:0], a ^ 32'h1234_5678};
  endfunction

  function automatic bit m_lookup(input logic [31:0] a, output int way);
    int idx = int'(a[4:1]);
    way = 0;
    for (int w = 0; w < 2; w++)
      if (m_valid[idx][w] && m_tag[idx][w] == a) begin way = w; return 1'b1; end
    return 1'b0;
  endfunction

  function automatic void m_fill(input logic [31:0] a, input logic [47:0] d);
    int idx = int'(a[4:1]);
    int v = int'(m_lru[idx]);
    m_valid[idx][v] = 1'b1;
    m_tag[idx][v]   = a;
    m_data[idx][v]  = d;
    m_lru[idx]      = (v == 0);
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < 16; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) m_valid[s][w] = 1'b0;
    end
    m_pend = 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input bit conf, input string req);
    int way;
    int idx = int'(a[4:1]);
    bit ext = (a >= EXT_BASE);
    bit exp_hit = cache_en && m_lookup(a, way);
    int cnt0;
    @(negedge clk);
    chk(fetch_ready == 1'b1, "R9", "ready when idle", 64'(fetch_ready), 64'd1);
    cnt0 = ext_cnt;
    fetch_valid = 1'b1; fetch_addr = a; fetch_conflict = conf;
    @(negedge clk);
    fetch_valid = 1'b0; fetch_conflict = 1'b0;
    if (exp_hit || !ext) begin
      chk(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_hit == exp_hit, req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
      chk(rsp_word == (exp_hit ? m_data[idx][way] : 48'd0), req, "rsp_word",
          64'(rsp_word), 64'(exp_hit ? m_data[idx][way] : 48'd0));
      chk(!ext_req_valid && ext_cnt == cnt0, exp_hit ? "R3" : "R4", "no external request",
          64'(ext_req_valid), 64'd0);
      if (exp_hit) m_lru[idx] = (way == 0);
      m_pend = !exp_hit && conf && cache_en;
      m_pend_addr = a;
    end else begin
      int d = $urandom_range(0, 3);
      chk(rsp_valid == 1'b0, req, "no response on miss", 64'(rsp_valid), 64'd0);
      chk(ext_req_valid && ext_req_addr == a, "R2", "ext request address", 64'(ext_req_addr), 64'(a));
      chk(fetch_ready == 1'b0, "R2", "ready low during miss", 64'(fetch_ready), 64'd0);
      repeat (d) begin
        @(negedge clk);
        chk(ext_req_valid && ext_req_addr == a, "R9", "request held", 64'(ext_req_addr), 64'(a));
      end
      ext_req_ready = 1'b1;
      @(negedge clk);
      ext_req_ready = 1'b0;
      repeat ($urandom_range(0, 4)) begin
        chk(!ext_req_valid && !fetch_ready && !rsp_valid, "R9", "single outstanding",
            64'({ext_req_valid, fetch_ready, rsp_valid}), 64'd0);
        @(negedge clk);
      end
      ext_rsp_valid = 1'b1; ext_rsp_word = ext_word(a);
      @(negedge clk);
      ext_rsp_valid = 1'b0;
      chk(rsp_valid && !rsp_hit, "R2", "miss response", 64'({rsp_valid, rsp_hit}), 64'b10);
      chk(rsp_word == ext_word(a), "R2", "forwarded word", 64'(rsp_word), 64'(ext_word(a)));
      chk(ext_cnt == cnt0 + 1, "R2", "one external request", 64'(ext_cnt - cnt0), 64'd1);
      if (cache_en) m_fill(a, ext_word(a));
      m_pend = 1'b0;
    end
  endtask

  task automatic give_iword(input logic [47:0] w);
    @(negedge clk);
    iword_valid = 1'b1; iword = w;
    @(negedge clk);
    iword_valid = 1'b0;
    if (m_pend && cache_en) m_fill(m_pend_addr, w);
    m_pend = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    m_clear();
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); cache_en = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a0, a1, a2, ia, ib;
    void'($urandom(32'd2024));
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_ready && !rsp_valid && !ext_req_valid, "R1", "reset outputs",
        64'({fetch_ready, rsp_valid, ext_req_valid}), 64'b100);

    // R2/R3 basic external miss then hit
    a0 = EXT_BASE | 32'h0000_0002;
    a1 = EXT_BASE | 32'h0000_0022;
    a2 = EXT_BASE | 32'h0000_0042;
    fetch(a0, 0, "R2");
    fetch(a0, 0, "R3");
    // R6: bit0 differs -> distinct line in the same set
    fetch(a0 | 32'h1, 0, "R6");
    fetch(a0, 0, "R6");
    fetch(a0 | 32'h1, 0, "R6");
    // R7: a0 MRU now? touch a0, then a1 evicts a0|1
    fetch(a0, 0, "R7");
    fetch(a1, 0, "R7");
    fetch(a0 | 32'h1, 0, "R7");
    fetch(a2, 0, "R7");
    fetch(a1, 0, "R7");

    // R4/R5 internal capture
    ia = INT_BASE | 32'h0000_0006;
    ib = INT_BASE | 32'h0000_0106;
    fetch(ia, 0, "R4");
    give_iword(int_word(ia));
    fetch(ia, 0, "R5");
    fetch(ia, 1, "R5");
    give_iword(int_word(ia));
    fetch(ia, 0, "R5");
    give_iword(int_word(ib));
    fetch(ib, 0, "R5");

    // R8 disable
    set_en(0);
    fetch(a1, 0, "R8");
    fetch(ib, 1, "R8");
    give_iword(int_word(ib));
    fetch(EXT_BASE | 32'h0000_0010, 0, "R8");
    set_en(1);
    fetch(ib, 0, "R8");
    fetch(a1, 0, "R8");
    fetch(EXT_BASE | 32'h0000_0010, 0, "R8");

    // R1 flush, also drops pending capture
    fetch(ib, 1, "R1");
    do_flush();
    give_iword(int_word(ib));
    fetch(ib, 0, "R1");
    fetch(a1, 0, "R1");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      bit ext = $urandom_range(0, 1) == 1;
      a = (ext ? EXT_BASE : INT_BASE) | (32'($urandom_range(0, 3)) << 5)
          | (32'($urandom_range(0, 2)) << 1);
      fetch(a, $urandom_range(0, 1) == 1, ext ? "R7" : "R5");
      if (!ext && $urandom_range(0, 1) == 1) give_iword(int_word(a));
      if ($urandom_range(0, 99) < 4) set_en(!cache_en);
      if ($urandom_range(0, 99) < 3) do_flush();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule